// File: doc/BRIEF.md
# Receive FIFO Interrupt Status Register

This block holds the receive sample queue of an audio capture peripheral and the 32-bit interrupt status word that reports on it. Captured samples enter through a push strobe. Software drains them one at a time through a holding-register read. Software also reads the status word to learn the queue state and to collect event flags.

Two kinds of flag share the status word. Level flags follow the queue occupancy: data ready, empty, full, and a chunk indicator compared against a programmable threshold. Sticky flags record events: overflow, underflow, and a write-protect violation reported by neighbouring logic. A status read clears each sticky flag, unless a new event for that flag arrives in the same cycle. The write-protect flag also stays set while its cause is still present. An interrupt line is driven high when any status bit is set and its bit in the enable mask is also set.

Top module: `rx_capture_status`

## Requirements
- R1: After reset the status word reads 0x00000002, with only the empty flag set, and the interrupt output is low.
- R2: Status bit positions: bit 0 data ready, bit 1 empty, bit 2 full, bit 3 chunk, bit 4 underflow, bit 5 overflow, bit 28 write-protect error. Every other bit reads 0.
- R3: The level flags reflect the stored entry count, which updates on the clock edge where a push or a pop is accepted. Data ready (bit 0) is high exactly when the count is non-zero. Empty (bit 1) is high exactly when the count is zero.
- R4: The chunk flag (bit 3) is high when the entry count is at least `chunkLevel`, and low otherwise.
- R5: The full flag (bit 2) is high when the count equals DEPTH.
- R6: A push while the queue is full, with no pop in the same cycle, drops the sample, leaves the queue contents unchanged, and sets the overflow flag (bit 5) from the next cycle.
- R7: A holding-register read while the queue is empty returns zero on `popData` in that cycle and sets the underflow flag (bit 4) from the next cycle.
- R8: A status read clears the overflow and underflow flags from the next cycle. If an event of the same kind occurs in the read cycle, that flag stays set.
- R9: The write-protect flag (bit 28) sets in the cycle after `wpViolation` is high. A status read clears it only if `wpViolation` is low in the read cycle.
- R10: `irq` is high exactly when at least one bit is set in both the status word and `irqEnable`.
- R11: Samples are returned in push order. A push and a pop in the same cycle are both accepted, even when the queue is full, and do not set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pushValid | input | 1 | Offer one captured sample to the queue |
| pushData | input | DW | Captured sample |
| popReq | input | 1 | Holding-register read; pops one entry |
| popData | output | DW | Head sample during `popReq`; zero when empty |
| statusRd | input | 1 | Status word read strobe |
| statusWord | output | 32 | Current status word |
| chunkLevel | input | clog2(DEPTH+1) | Chunk threshold in entries |
| wpViolation | input | 1 | Write-protect violation cause, level |
| irqEnable | input | 32 | Interrupt enable mask, one bit per status bit |
| irq | output | 1 | Masked interrupt request |

## Verification
Several properties are checked on every cycle. An overflow or underflow condition must raise its sticky flag one cycle later. An empty-queue read must return zero. A sticky flag must hold until a status read. A violation must set the protection flag. Reserved bits must stay clear, and data ready and empty must never agree. Some behaviours need multi-step sequences, and only the bench scenarios show them. These are sample ordering through the queue, the chunk and full thresholds at a chosen level, an event that coincides with a clear, the protection flag that refuses to clear while its cause persists, and the effect of the enable mask on `irq`.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

  typedef struct packed {
    logic pushEn;
    logic popEn;
    logic ovfEvt;
    logic udfEvt;
    logic stClr;
  } rxStrobe_t;

  localparam int BIT_RDY   = 0;
  localparam int BIT_EMPTY = 1;
  localparam int BIT_FULL  = 2;
  localparam int BIT_CHUNK = 3;
  localparam int BIT_UDF   = 4;
  localparam int BIT_OVF   = 5;
  localparam int BIT_WP    = 28;

endpackage

// File: rtl/rx_stat_ctrl.sv
module rx_stat_ctrl
  import rx_stat_pkg::*;
(
  input  logic      pushValid,
  input  logic      popReq,
  input  logic      statusRd,
  input  logic      isFull,
  input  logic      isEmpty,
  output rxStrobe_t strobe
);

  always_comb begin
    strobe.popEn  = popReq & ~isEmpty;
    // a pop in the same cycle frees a slot, so a full queue still takes the push
    strobe.pushEn = pushValid & (~isFull | popReq);
    strobe.ovfEvt = pushValid & isFull & ~popReq;
    strobe.udfEvt = popReq & isEmpty;
    strobe.stClr  = statusRd;
  end

endmodule

// File: rtl/rx_stat_dp.sv
module rx_stat_dp
  import rx_stat_pkg::*;
#(
  parameter int DW    = 24,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rxStrobe_t                    strobe,
  input  logic [DW-1:0]                pushData,
  input  logic [$clog2(DEPTH+1)-1:0]   chunkLevel,
  input  logic                         wpViolation,
  output logic                         isFull,
  output logic                         isEmpty,
  output logic [DW-1:0]                popData,
  output logic [31:0]                  statusWord
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          ovfFlag, udfFlag, wpFlag;

  assign isEmpty = (count == '0);
  assign isFull  = (count == CW'(DEPTH));
  assign popData = isEmpty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.pushEn) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.pushEn) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strobe.popEn)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({strobe.pushEn, strobe.popEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // sticky events: a new event wins over the clear of the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      udfFlag <= 1'b0;
      wpFlag  <= 1'b0;
    end else begin
      ovfFlag <= strobe.ovfEvt | (ovfFlag & ~strobe.stClr);
      udfFlag <= strobe.udfEvt | (udfFlag & ~strobe.stClr);
      wpFlag  <= wpViolation   | (wpFlag  & ~strobe.stClr);
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[BIT_RDY]   = ~isEmpty;
    statusWord[BIT_EMPTY] = isEmpty;
    statusWord[BIT_FULL]  = isFull;
    statusWord[BIT_CHUNK] = (count >= chunkLevel);
    statusWord[BIT_UDF]   = udfFlag;
    statusWord[BIT_OVF]   = ovfFlag;
    statusWord[BIT_WP]    = wpFlag;
  end

endmodule

// File: rtl/rx_capture_status.sv
module rx_capture_status
  import rx_stat_pkg::*;
#(
  parameter int DW    = 24,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         pushValid,
  input  logic [DW-1:0]                pushData,
  input  logic                         popReq,
  output logic [DW-1:0]                popData,
  input  logic                         statusRd,
  output logic [31:0]                  statusWord,
  input  logic [$clog2(DEPTH+1)-1:0]   chunkLevel,
  input  logic                         wpViolation,
  input  logic [31:0]                  irqEnable,
  output logic                         irq
);

  rxStrobe_t strobe;
  logic      isFull, isEmpty;

  rx_stat_ctrl u_ctrl (
    .pushValid (pushValid),
    .popReq    (popReq),
    .statusRd  (statusRd),
    .isFull    (isFull),
    .isEmpty   (isEmpty),
    .strobe    (strobe)
  );

  rx_stat_dp #(.DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pushData    (pushData),
    .chunkLevel  (chunkLevel),
    .wpViolation (wpViolation),
    .isFull      (isFull),
    .isEmpty     (isEmpty),
    .popData     (popData),
    .statusWord  (statusWord)
  );

  assign irq = |(statusWord & irqEnable);

endmodule

// File: rtl/rx_stat_chk.sv
module rx_stat_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          pushValid,
  input logic          popReq,
  input logic          statusRd,
  input logic          wpViolation,
  input logic [31:0]   statusWord,
  input logic [DW-1:0] popData
);

  a_r6_overflow_sets: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[2] && pushValid && !popReq |=> statusWord[5]);

  a_r7_underflow_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[1] && popReq |-> popData == '0);

  a_r7_underflow_sets: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[1] && popReq |=> statusWord[4]);

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[5] && !statusRd |=> statusWord[5]);

  a_r9_wp_sets: assert property (@(posedge clk) disable iff (!rstN)
    wpViolation |=> statusWord[28]);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & ~32'h1000_003F) == 32'h0);

  a_r3_ready_vs_empty: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[0] != statusWord[1]);

endmodule

bind rx_capture_status rx_stat_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pushValid   (pushValid),
  .popReq      (popReq),
  .statusRd    (statusRd),
  .wpViolation (wpViolation),
  .statusWord  (statusWord),
  .popData     (popData)
);

// File: tb/test_rx_capture_status.sv
`timescale 1ns/1ps
module test_rx_capture_status;

  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic        push;
    logic [7:0]  data;
    logic        pop;
    logic        rd;
    logic        wp;
    logic [31:0] expSt;
    logic [7:0]  expPop;
  } vec_t;

  // chunk threshold 3, depth 4; expected status is read after the edge
  localparam vec_t VEC [16] = '{
    '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 32'h0000_0001, 8'h00}, // R3 first push
    '{1'b1, 8'hA2, 1'b0, 1'b0, 1'b0, 32'h0000_0001, 8'h00}, // R4 below chunk
    '{1'b1, 8'hA3, 1'b0, 1'b0, 1'b0, 32'h0000_0009, 8'h00}, // R4 at chunk
    '{1'b1, 8'hA4, 1'b0, 1'b0, 1'b0, 32'h0000_000D, 8'h00}, // R5 full
    '{1'b1, 8'hEE, 1'b0, 1'b0, 1'b0, 32'h0000_002D, 8'h00}, // R6 overflow
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0000_000D, 8'h00}, // R8 clear
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 32'h0000_0009, 8'hA1}, // R11 order
    '{1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 32'h0000_0009, 8'hA2}, // R11 push+pop
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 32'h0000_0001, 8'hA3}, // R4 below chunk
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 32'h0000_0001, 8'hA4}, // R11
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 32'h0000_0002, 8'hA5}, // R3 empty again
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 32'h0000_0012, 8'h00}, // R7 underflow
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0000_0002, 8'h00}, // R8 clear
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 32'h1000_0002, 8'h00}, // R9 set
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 32'h1000_0002, 8'h00}, // R9 held by cause
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 32'h0000_0002, 8'h00}  // R9 cleared
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pushValid = 1'b0;
  logic [DW-1:0] pushData = '0;
  logic          popReq = 1'b0;
  logic [DW-1:0] popData;
  logic          statusRd = 1'b0;
  logic [31:0]   statusWord;
  logic [CW-1:0] chunkLevel = CW'(3);
  logic          wpViolation = 1'b0;
  logic [31:0]   irqEnable = '0;
  logic          irq;

  int nChecks = 0;
  int nFail = 0;
  logic [DW-1:0] popSeen;

  always #2 clk = ~clk;

  rx_capture_status #(.DW(DW), .DEPTH(DEPTH)) i_rx_capture_status (
    .clk         (clk),
    .rstN        (rstN),
    .pushValid   (pushValid),
    .pushData    (pushData),
    .popReq      (popReq),
    .popData     (popData),
    .statusRd    (statusRd),
    .statusWord  (statusWord),
    .chunkLevel  (chunkLevel),
    .wpViolation (wpViolation),
    .irqEnable   (irqEnable),
    .irq         (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic push, input logic [7:0] data, input logic pop,
                     input logic rd, input logic wp);
    pushValid = push; pushData = data; popReq = pop; statusRd = rd; wpViolation = wp;
    #1 popSeen = popData;
    @(negedge clk);
    pushValid = 1'b0; popReq = 1'b0; statusRd = 1'b0; wpViolation = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    irqEnable = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset status", statusWord, 32'h0000_0002);
    irqEnable = '0;
    #0.5 check("R1 reset irq low under zero mask", {31'b0, irq}, 32'd0);

    irqEnable = 32'hFFFF_FFFF;
    for (int i = 0; i < 16; i++) begin
      cyc(VEC[i].push, VEC[i].data, VEC[i].pop, VEC[i].rd, VEC[i].wp);
      check($sformatf("R3 R4 R5 R6 R7 R8 R9 vector %0d status", i), statusWord, VEC[i].expSt);
      check("R2 reserved bits", statusWord & ~32'h1000_003F, 32'h0);
      if (VEC[i].pop)
        check($sformatf("R11 R7 vector %0d popData", i), {24'b0, popSeen}, {24'b0, VEC[i].expPop});
    end

    // R8: overflow in the same cycle as a status read survives
    for (int k = 0; k < DEPTH; k++) cyc(1'b1, 8'h10 + 8'(k), 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 8'h77, 1'b0, 1'b1, 1'b0);
    check("R8 event during read stays set", {31'b0, statusWord[5]}, 32'd1);
    // R10: mask selects overflow only
    irqEnable = 32'h0000_0020;
    #0.5 check("R10 irq with overflow enabled", {31'b0, irq}, 32'd1);
    irqEnable = 32'h1000_0010;
    #0.5 check("R10 irq with overflow masked", {31'b0, irq}, 32'd0);
    irqEnable = 32'hFFFF_FFFF;
    @(negedge clk);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R8 cleared by later read", statusWord, 32'h0000_000D);

    // R11: push and pop while full, no overflow, order kept
    cyc(1'b1, 8'h55, 1'b1, 1'b0, 1'b0);
    check("R11 full push+pop data", {24'b0, popSeen}, 32'h10);
    check("R11 full push+pop status", statusWord, 32'h0000_000D);
    for (int k = 1; k < DEPTH; k++) cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R11 last sample after wrap", {24'b0, popSeen}, 32'h55);
    check("R3 empty after drain", statusWord, 32'h0000_0002);

    // R4: threshold 1 asserts chunk with one entry
    chunkLevel = CW'(1);
    cyc(1'b1, 8'h99, 1'b0, 1'b0, 1'b0);
    check("R4 chunk at level 1", statusWord, 32'h0000_0009);

    // R1: reset mid-stream returns to the reset word
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status after second reset", statusWord, 32'h0000_0002);

    summary();
  end

endmodule